// File: doc/BRIEF.md
# Reference-Table Sample Mismatch Detector

This block watches a stream of ADC samples and compares each one, as it arrives, with an expected value taken from a writable waveform table. A pointer into the table advances on every accepted sample and wraps at the table depth. Before a run, software loads that pointer so that the table lines up with the phase of the periodic stimulus. A signed offset is added to every table value, so that a measured mean difference can be trimmed out. When the magnitude of the difference is larger than a threshold set at run time, the block records an event: it sets a sticky flag, bumps a saturating counter and triggers a circular capture buffer.

Once triggered, the capture buffer records a fixed number of further samples and then freezes. The frozen buffer holds samples from before and after the event, and software reads it out through a read port. A small register port loads the table, the offset, the threshold and the table pointer, and drives a control word. The control word holds the enable and three one-shot actions: error injection, flag clear and capture re-arm. Injection lets the detector be exercised without any real upset.

Top module: `ref_mismatch_checker`

## Requirements
- R1: After reset, err_flag is 0, err_count is 0 and cap_frozen is 0.
- R2: While the compare enable (control bit 0) is 1, a sample is an event exactly when |sample − (table value + offset)| is strictly greater than the threshold; a difference equal to the threshold is not an event, and no sample accepted while the enable is 0 is an event.
- R3: The table pointer advances by one on every accepted sample, whether or not compare is enabled, and wraps modulo TDEPTH (a power of two); a write with reg_sel = 3 loads the pointer from reg_wdata, and that entry is the one compared against the next sample.
- R4: The offset (reg_sel = 1) is a two's-complement value of SW+1 bits, and it is added to every table value before the difference is taken.
- R5: err_flag is set by an event and stays set until a control write (reg_sel = 4) with bit 2 at 1 clears it.
- R6: err_count increments by one per event and holds at all ones once it reaches that value.
- R7: A control write with bit 1 at 1 forces the next sample compared while enabled to be an event, whatever its value; the sample after it is compared normally.
- R8: Every accepted sample is written into a circular capture RAM of CDEPTH entries. The first event while the buffer is armed triggers it. After POST further samples the buffer freezes (cap_frozen = 1) and stops writing. cap_oldest then addresses the oldest entry, and the event sample sits at cap_oldest + CDEPTH − 1 − POST (mod CDEPTH).
- R9: A control write with bit 3 at 1 re-arms the buffer: cap_frozen drops, writing resumes, and the next event triggers a new capture.
- R10: A table write (reg_sel = 0, entry reg_idx, value reg_wdata[SW-1:0]) made while compare is enabled is used only from the wrap of the pointer back to entry 0 that follows it. A table write made while compare is disabled is used from the next cycle on.
- R11: cap_rd_data shows the capture entry addressed by cap_rd_addr one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | SW | Unsigned ADC sample |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 table, 1 offset, 2 threshold, 3 pointer, 4 control |
| reg_idx | input | $clog2(TDEPTH) | Table entry for a table write |
| reg_wdata | input | SW+1 | Write data |
| cap_rd_addr | input | $clog2(CDEPTH) | Capture read address |
| err_flag | output | 1 | Sticky event flag |
| err_count | output | CNT_W | Saturating event count |
| cap_frozen | output | 1 | Capture buffer frozen |
| cap_oldest | output | $clog2(CDEPTH) | Capture write pointer (oldest entry when frozen) |
| cap_rd_data | output | SW | Capture read data |

## Verification
The bench builds the block with TDEPTH = 16, CDEPTH = 16, POST = 8 and CNT_W = 5, and keeps the 12-bit sample width. With these values every table entry and both wraps of the pointer come up within a few dozen samples. The whole capture buffer can be read back and compared entry by entry, and the counter reaches its saturation value within the run. The bench sweeps the difference across each side of several thresholds and offsets, and predicts every flag, count and capture entry arithmetically.

// File: rtl/smc_pkg.sv
package smc_pkg;
    typedef enum logic [2:0] {
        SEL_TABLE  = 3'd0,
        SEL_OFFSET = 3'd1,
        SEL_THRESH = 3'd2,
        SEL_PHASE  = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    localparam int CTL_ENABLE = 0;
    localparam int CTL_INJECT = 1;
    localparam int CTL_CLEAR  = 2;
    localparam int CTL_REARM  = 3;
endpackage

// File: rtl/smc_ref_table.sv
// Two-bank expected-value table. Each entry has a live-bank bit; writes land
// in the other bank and become live only when commit is pulsed.
module smc_ref_table #(
    parameter int SW    = 12,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [SW-1:0] wr_data,
    input  logic          commit,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0] live;
        logic [DEPTH-1:0] pend;
    } tbl_st_t;

    tbl_st_t q, n;
    logic    wr_bank;

    logic [SW-1:0] bank0 [DEPTH];
    logic [SW-1:0] bank1 [DEPTH];

    always_comb begin
        n = q;
        if (commit) begin
            n.live = q.live ^ q.pend;
            n.pend = '0;
        end
        if (wr_en) begin
            n.pend[wr_idx] = 1'b1;
        end
        wr_bank = ~n.live[wr_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_bank) bank1[wr_idx] <= wr_data;
            else         bank0[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= q.live[rd_addr] ? bank1[rd_addr] : bank0[rd_addr];
        end
    end

    // R10
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(q.live))
        else $error("live bank map changed without commit");
endmodule

// File: rtl/smc_capture.sv
// Circular capture RAM with post-trigger countdown and freeze.
module smc_capture #(
    parameter int SW    = 12,
    parameter int DEPTH = 4096,
    parameter int POST  = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(POST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_vld,
    input  logic [SW-1:0] wr_data,
    input  logic          trig,
    input  logic          rearm,
    input  logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_data,
    output logic          frozen,
    output logic [AW-1:0] oldest
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic          trig;
        logic          frozen;
        logic [PW-1:0] left;
    } cap_st_t;

    cap_st_t q, n;
    logic    we;

    logic [SW-1:0] mem [DEPTH];

    always_comb begin
        n = q;
        if (rearm) begin
            n.trig   = 1'b0;
            n.frozen = 1'b0;
        end
        we = wr_vld && !n.frozen;
        if (we) begin
            n.wp = q.wp + 1'b1;
            if (n.trig) begin
                n.left = q.left - 1'b1;
                if (q.left == PW'(1)) n.frozen = 1'b1;
            end else if (trig) begin
                n.trig = 1'b1;
                n.left = PW'(POST);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk) begin
        if (we) mem[q.wp] <= wr_data;
        rd_data <= mem[rd_addr];
    end

    assign frozen = q.frozen;
    assign oldest = q.wp;

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.frozen && !rearm |=> q.frozen && $stable(q.wp))
        else $error("capture moved while frozen");

    // R8
    post_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.trig && !q.frozen |-> q.left != '0 && q.left <= PW'(POST))
        else $error("post-trigger count out of range");
endmodule

// File: rtl/ref_mismatch_checker.sv
module ref_mismatch_checker import smc_pkg::*; #(
    parameter int SW     = 12,
    parameter int TDEPTH = 1024,
    parameter int CDEPTH = 4096,
    parameter int POST   = 2048,
    parameter int CNT_W  = 16,
    localparam int TAW   = $clog2(TDEPTH),
    localparam int CAW   = $clog2(CDEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SW-1:0]    smp_data,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [TAW-1:0]   reg_idx,
    input  logic [SW:0]      reg_wdata,
    input  logic [CAW-1:0]   cap_rd_addr,
    output logic             err_flag,
    output logic [CNT_W-1:0] err_count,
    output logic             cap_frozen,
    output logic [CAW-1:0]   cap_oldest,
    output logic [SW-1:0]    cap_rd_data
);
    localparam int DW = SW + 3;

    typedef struct packed {
        logic [TAW-1:0]   addr;
        logic             en;
        logic             inj;
        logic [SW:0]      off;
        logic [SW:0]      thr;
        logic             chk;
        logic             cinj;
        logic             wv;
        logic [SW-1:0]    smp;
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              q, n;
    reg_sel_e         sel;
    logic [SW-1:0]    exp_val;
    logic             commit, hit, clr, rearm, tbl_wr, phase_wr;
    logic signed [DW-1:0] smp_s, exp_s, off_s, diff;
    logic [DW-1:0]    mag;

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        tbl_wr   = reg_wr && (sel == SEL_TABLE);
        phase_wr = reg_wr && (sel == SEL_PHASE);
        clr      = reg_wr && (sel == SEL_CTRL) && reg_wdata[CTL_CLEAR];
        rearm    = reg_wr && (sel == SEL_CTRL) && reg_wdata[CTL_REARM];
        commit   = !q.en || (smp_valid && (q.addr == TAW'(TDEPTH - 1)));

        smp_s = {{(DW-SW){1'b0}}, q.smp};
        exp_s = {{(DW-SW){1'b0}}, exp_val};
        off_s = {{(DW-SW-1){q.off[SW]}}, q.off};
        diff  = smp_s - (exp_s + off_s);
        mag   = diff[DW-1] ? DW'(-diff) : DW'(diff);
        hit   = q.chk && (q.cinj || (mag > {{(DW-SW-1){1'b0}}, q.thr}));

        n      = q;
        n.chk  = smp_valid && q.en;
        n.cinj = smp_valid && q.en && q.inj;
        n.wv   = smp_valid;
        n.smp  = smp_data;
        if (smp_valid) begin
            n.addr = q.addr + 1'b1;
            if (q.en) n.inj = 1'b0;
        end
        if (reg_wr) begin
            case (sel)
                SEL_OFFSET: n.off  = reg_wdata;
                SEL_THRESH: n.thr  = reg_wdata;
                SEL_PHASE:  n.addr = reg_wdata[TAW-1:0];
                SEL_CTRL: begin
                    n.en = reg_wdata[CTL_ENABLE];
                    if (reg_wdata[CTL_INJECT]) n.inj = 1'b1;
                end
                default: ;
            endcase
        end
        if (clr) n.flag = 1'b0;
        if (hit) begin
            n.flag = 1'b1;
            if (q.cnt != '1) n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    smc_ref_table #(.SW(SW), .DEPTH(TDEPTH)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_idx  (reg_idx),
        .wr_data (reg_wdata[SW-1:0]),
        .commit  (commit),
        .rd_en   (smp_valid),
        .rd_addr (q.addr),
        .rd_data (exp_val)
    );

    smc_capture #(.SW(SW), .DEPTH(CDEPTH), .POST(POST)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_vld  (q.wv),
        .wr_data (q.smp),
        .trig    (hit),
        .rearm   (rearm),
        .rd_addr (cap_rd_addr),
        .rd_data (cap_rd_data),
        .frozen  (cap_frozen),
        .oldest  (cap_oldest)
    );

    assign err_flag  = q.flag;
    assign err_count = q.cnt;

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt == '1 |=> q.cnt == '1)
        else $error("event counter left saturation");

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && q.cnt != '1 |=> q.cnt == $past(q.cnt) + 1'b1)
        else $error("event counter did not step");

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.flag && !clr |=> q.flag)
        else $error("flag dropped without clear");

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !phase_wr |=> q.addr == $past(q.addr) + 1'b1)
        else $error("table pointer did not advance");
endmodule

// File: tb/ref_mismatch_checker_bench.sv
module ref_mismatch_checker_bench;
    localparam int SW  = 12;
    localparam int TD  = 16;
    localparam int CD  = 16;
    localparam int PO  = 8;
    localparam int CW  = 5;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [3:0]  reg_idx = '0;
    logic [12:0] reg_wdata = '0;
    logic [3:0]  cap_rd_addr = '0;
    logic        err_flag;
    logic [4:0]  err_count;
    logic        cap_frozen;
    logic [3:0]  cap_oldest;
    logic [11:0] cap_rd_data;

    always #5 clk = ~clk;

    ref_mismatch_checker #(.SW(SW), .TDEPTH(TD), .CDEPTH(CD), .POST(PO), .CNT_W(CW))
    u_ref_mismatch_checker (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .cap_rd_addr(cap_rd_addr), .err_flag(err_flag), .err_count(err_count),
        .cap_frozen(cap_frozen), .cap_oldest(cap_oldest), .cap_rd_data(cap_rd_data)
    );

    int vec_n = 0;
    int bad_n = 0;
    bit done = 1'b0;

    // bench model
    int tbl_m [TD];
    int pend_v [TD];
    bit pend_f [TD];
    int cap_m [CD];
    int off_m = 0, thr_m = 0, addr_m = 0, cnt_m = 0;
    int wp_m = 0, left_m = 0, trig_val = 0;
    bit en_m = 0, inj_m = 0, flag_m = 0, trig_m = 0, frozen_m = 0;

    task automatic check(string req, int act, int exp);
        vec_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic commit_m();
        for (int i = 0; i < TD; i++) begin
            if (pend_f[i]) begin
                tbl_m[i] = pend_v[i];
                pend_f[i] = 1'b0;
            end
        end
    endtask

    task automatic idle(int k);
        repeat (k) begin
            @(negedge clk);
            smp_valid = 1'b0;
            reg_wr = 1'b0;
        end
    endtask

    task automatic wr(int sel, int idx, int data);
        @(negedge clk);
        smp_valid = 1'b0;
        reg_wr = 1'b1;
        reg_sel = 3'(sel);
        reg_idx = 4'(idx);
        reg_wdata = 13'(data);
        case (sel)
            0: begin
                if (en_m) begin
                    pend_v[idx] = data;
                    pend_f[idx] = 1'b1;
                end else begin
                    tbl_m[idx] = data;
                end
            end
            1: off_m = (data >= 4096) ? data - 8192 : data;
            2: thr_m = data;
            3: addr_m = data % TD;
            default: begin
                en_m = data[0];
                if (data[1]) inj_m = 1'b1;
                if (data[2]) flag_m = 1'b0;
                if (data[3]) begin
                    trig_m = 1'b0;
                    frozen_m = 1'b0;
                end
                if (!en_m) commit_m();
            end
        endcase
    endtask

    task automatic push(int s);
        int d;
        bit ev;
        @(negedge clk);
        reg_wr = 1'b0;
        smp_valid = 1'b1;
        smp_data = 12'(s);
        ev = 1'b0;
        if (en_m) begin
            d = s - (tbl_m[addr_m] + off_m);
            if (d < 0) d = -d;
            ev = inj_m || (d > thr_m);
            inj_m = 1'b0;
            if (ev) begin
                flag_m = 1'b1;
                if (cnt_m < CMAX) cnt_m++;
            end
            if (addr_m == TD - 1) commit_m();
        end
        addr_m = (addr_m + 1) % TD;
        if (!frozen_m) begin
            cap_m[wp_m] = s;
            wp_m = (wp_m + 1) % CD;
            if (trig_m) begin
                left_m--;
                if (left_m == 0) frozen_m = 1'b1;
            end else if (ev) begin
                trig_m = 1'b1;
                left_m = PO;
                trig_val = s;
            end
        end
    endtask

    task automatic step(int s, string tag);
        push(s);
        idle(3);
        check($sformatf("%s flag", tag), int'(err_flag), int'(flag_m));
        check($sformatf("%s count", tag), int'(err_count), cnt_m);
        check($sformatf("%s frozen", tag), int'(cap_frozen), int'(frozen_m));
        if (flag_m) begin
            idle(4);
            check("R5 flag held", int'(err_flag), 1);
            wr(4, 0, 5);
            idle(2);
            check("R5 flag cleared", int'(err_flag), 0);
        end
    endtask

    task automatic read_capture(string tag);
        check($sformatf("%s oldest", tag), int'(cap_oldest), wp_m);
        for (int i = 0; i < CD; i++) begin
            @(negedge clk);
            cap_rd_addr = 4'(i);
            @(negedge clk);
            check($sformatf("R11 %s entry %0d", tag, i), int'(cap_rd_data), cap_m[i]);
        end
        @(negedge clk);
        cap_rd_addr = 4'((wp_m + CD - 1 - PO) % CD);
        @(negedge clk);
        check($sformatf("R8 %s trigger slot", tag), int'(cap_rd_data), trig_val);
    endtask

    initial begin
        for (int i = 0; i < TD; i++) pend_f[i] = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 flag", int'(err_flag), 0);
        check("R1 count", int'(err_count), 0);
        check("R1 frozen", int'(cap_frozen), 0);

        for (int i = 0; i < TD; i++) wr(0, i, 1348 + 100 * i);
        wr(2, 0, 5);
        wr(4, 0, 1);
        idle(2);

        // R3 aligned exact stream over a full period
        for (int i = 0; i < TD; i++) step(tbl_m[addr_m], "R3 aligned");

        // R2 threshold sweeps, first event triggers capture (R8)
        foreach (thr_vals[k]) ;
        wr(2, 0, 5);
        for (int d = -7; d <= 7; d++) step(tbl_m[addr_m] + d, "R2 thr5");
        check("R8 frozen after post window", int'(cap_frozen), 1);
        read_capture("R8 first");

        wr(4, 0, 9);
        idle(2);
        check("R9 rearm unfreezes", int'(cap_frozen), 0);

        wr(2, 0, 2);
        for (int d = -7; d <= 7; d++) step(tbl_m[addr_m] + d, "R2 thr2");

        // R4 offsets
        wr(1, 0, (-30) & 13'h1fff);
        wr(2, 0, 3);
        for (int d = -5; d <= 5; d++) step(tbl_m[addr_m] - 30 + d, "R4 neg offset");
        wr(1, 0, 40);
        for (int d = -4; d <= 4; d += 4) step(tbl_m[addr_m] + 40 + d, "R4 pos offset");
        wr(1, 0, 0);

        // R9 capture retriggered after rearm
        read_capture("R9 second");

        // R7 injection one-shot
        wr(4, 0, 3);
        step(tbl_m[addr_m], "R7 injected");
        step(tbl_m[addr_m], "R7 after inject");

        // R3 phase load
        wr(3, 0, 9);
        step(tbl_m[9], "R3 phase hit");
        step(tbl_m[0], "R3 phase miss");

        // R10 staged table write while enabled
        wr(3, 0, 3);
        wr(0, 5, tbl_m[5] + 50);
        for (int i = 3; i < TD; i++) step(tbl_m[addr_m], "R10 old value in use");
        for (int i = 0; i < 6; i++) step(tbl_m[addr_m], "R10 new value after wrap");
        check("R10 staged entry", tbl_m[5], 1348 + 550);

        // R2 disabled compare, R10 immediate write while disabled
        wr(4, 0, 0);
        for (int i = 0; i < 4; i++) step(tbl_m[addr_m] + 500, "R2 disabled");
        wr(0, 6, 3000);
        wr(3, 0, 6);
        wr(4, 0, 1);
        idle(2);
        step(3000, "R10 disabled write");

        // R6 saturation
        wr(2, 0, 0);
        for (int i = 0; i < 40; i++) step(tbl_m[addr_m] + 1, "R6 saturate");
        check("R6 saturated", int'(err_count), CMAX);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    int thr_vals [1] = '{0};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad_n++;
            vec_n++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
            $finish;
        end
    end
endmodule